// File: doc/BRIEF.md
# Octant-Folded Sine/Cosine Lookup Unit

This unit converts a binary phase index into the sine and cosine of the matching angle on a uniform circle. The angle is 2π·n/2^W, where W is the width of the index. An index n returns sin and cos of 2π·n/2^W. Each result comes out as an unsigned fixed-point magnitude plus a separate sign bit.

Only the first eighth of the circle is stored. The index is reflected into that octant by complementing its low bits. The unit then reads sine and cosine magnitudes from a small table and restores the full-circle result:

- An exclusive-or of the upper index bits gives the sign bits.
- A multiplexer exchanges the two magnitudes in the octants that mirror across π/4.

The angle π/4 itself falls one entry past the table, so it is detected and answered by a constant. Results are registered once, and the update is qualified by an input strobe. The unit suits NCO phase-to-amplitude conversion and transform twiddle generation.

Top module: `octsc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are all zero: `out_valid`, both magnitudes and both sign bits.
- R2: `out_valid` equals `in_valid` of the previous cycle. When `in_valid` is low, the magnitudes and sign bits keep their previous values whatever `in_phase` does.
- R3: For every index n, each magnitude is within 1 LSB of |sin| or |cos| of 2π·n/2^W. The reference value is scaled by 2^FRAC_W, rounded to nearest and saturated at 2^FRAC_W−1.
- R4: `sin_neg` equals bit W−1 of the captured index, so the second half of the circle has a negative sine.
- R5: `cos_neg` equals bit W−1 XOR bit W−2 of the captured index, so the second and third quadrants have a negative cosine.
- R6: The index reaches π/4 in its quadrant when bit W−3 is 1 and bits W−4..0 are 0. For such an index both magnitudes equal round(2^FRAC_W/√2), which is 2896 for FRAC_W = 12.
- R7: Index 0 gives a sine magnitude of 0 and a cosine magnitude of all ones, because the value 1.0 is saturated.
- R8: At any multiple of a quarter period (bits W−3..0 all zero), one magnitude is 0 and the other is all ones.
- R9: PHASE_W must be at least 4, so that the period is a multiple of four and the octant has at least one address bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe for `in_phase` |
| in_phase | input | PHASE_W | Unsigned phase index n |
| out_valid | output | 1 | Result registered this cycle |
| sin_mag | output | FRAC_W | Sine magnitude, unsigned Q0.FRAC_W |
| sin_neg | output | 1 | Sine sign, 1 = negative |
| cos_mag | output | FRAC_W | Cosine magnitude, unsigned Q0.FRAC_W |
| cos_neg | output | 1 | Cosine sign, 1 = negative |

## Verification
Eight directed vectors cover the quadrant points and the π/4 diagonals of all four quadrants. These separate faults in the sign exclusive-or, in saturation, and in the boundary constant from faults in the table itself.

An exhaustive sweep of all 2^W indices against a real-valued model then exercises every pair of octants that mirror one another. A wrong reflection address, a missing swap or a shifted table entry therefore shows up as a magnitude error larger than one LSB.

Directed sequences hold `in_valid` low while the phase changes, and apply reset with the strobe high. These separate the capture qualification from the reset path.

// File: rtl/octsc_pkg.sv
// Package for the octant-folded sine/cosine unit.
// Holds the elaboration-time function that quantizes first-octant
// magnitudes. Assumes frac_w <= 30 so scale factors fit in an int.
package octsc_pkg;

    localparam real QUARTER_PI = 0.78539816339744830962;

    // Rounded, saturated magnitude of sin or cos at angle k*(pi/4)/2^oct_w.
    function automatic int oct_mag(input int k, input int oct_w,
                                   input int frac_w, input bit want_cos);
        real ang;
        real v;
        int  q;
        int  top;
        top = (1 << frac_w) - 1;
        ang = QUARTER_PI * real'(k) / real'(1 << oct_w);
        v   = want_cos ? $cos(ang) : $sin(ang);
        q   = $rtoi(v * real'(1 << frac_w) + 0.5);
        if (q > top) q = top;
        return q;
    endfunction

    // Rounded magnitude of 1/sqrt(2) on frac_w fractional bits.
    function automatic int diag_mag(input int frac_w);
        return $rtoi(0.70710678118654752440 * real'(1 << frac_w) + 0.5);
    endfunction

endpackage

// File: rtl/octsc_fold.sv
// Index folder: maps a W-bit phase index onto a first-octant table
// address. It also flags the pi/4 boundary entry and produces the swap
// and sign controls. Purely combinational. Assumes PHASE_W >= 4.
module octsc_fold #(
    parameter int PHASE_W = 8
) (
    input  logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-4:0] addr,
    output logic               diag,
    output logic               swap,
    output logic               sneg,
    output logic               cneg
);
    localparam int OW = PHASE_W - 3;

    logic [OW-1:0] low;
    logic [OW:0]   refl;
    logic          oct_b;
    logic          quad_b;
    logic          half_b;

    assign low    = phase[OW-1:0];
    assign oct_b  = phase[OW];
    assign quad_b = phase[OW+1];
    assign half_b = phase[OW+2];

    // Reflection 2^OW - low, formed as a two's complement of the low bits.
    assign refl = {1'b1, {OW{1'b0}}} - {1'b0, low};

    // Address, boundary flag and swap select from the octant and quadrant bits.
    always_comb begin
        if (oct_b) begin
            addr = refl[OW-1:0];
            diag = (low == '0);
        end else begin
            addr = low;
            diag = 1'b0;
        end
        swap = oct_b ^ quad_b;
    end

    // Signs come from the upper index bits only.
    assign sneg = half_b;
    assign cneg = half_b ^ quad_b;

endmodule

// File: rtl/octsc_rom.sv
// First-octant magnitude table: 2^(PHASE_W-3) entries of sine and
// cosine, filled at elaboration. A separate constant serves the pi/4
// boundary entry. Combinational read.
module octsc_rom #(
    parameter int PHASE_W = 8,
    parameter int FRAC_W  = 12
) (
    input  logic [PHASE_W-4:0] addr,
    input  logic               diag,
    output logic [FRAC_W-1:0]  rd_sin,
    output logic [FRAC_W-1:0]  rd_cos
);
    localparam int OW    = PHASE_W - 3;
    localparam int DEPTH = 1 << OW;
    localparam logic [FRAC_W-1:0] DIAG_VAL = FRAC_W'(octsc_pkg::diag_mag(FRAC_W));

    logic [FRAC_W-1:0] sin_tab [DEPTH];
    logic [FRAC_W-1:0] cos_tab [DEPTH];

    // One sine and one cosine constant per octant step.
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign sin_tab[k] = FRAC_W'(octsc_pkg::oct_mag(k, OW, FRAC_W, 1'b0));
        assign cos_tab[k] = FRAC_W'(octsc_pkg::oct_mag(k, OW, FRAC_W, 1'b1));
    end

    // Table read, overridden by the diagonal constant at the boundary.
    always_comb begin
        if (diag) begin
            rd_sin = DIAG_VAL;
            rd_cos = DIAG_VAL;
        end else begin
            rd_sin = sin_tab[addr];
            rd_cos = cos_tab[addr];
        end
    end

endmodule

// File: rtl/octsc_unit.sv
// Octant-folded sine/cosine lookup unit, top level.
// Folds the index, reads the octant table, swaps the magnitudes where
// the fold needs it and registers sign-magnitude results on in_valid.
// Assumes PHASE_W >= 4 and FRAC_W <= 30.
module octsc_unit #(
    parameter int PHASE_W = 8,
    parameter int FRAC_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PHASE_W-1:0] in_phase,
    output logic               out_valid,
    output logic [FRAC_W-1:0]  sin_mag,
    output logic               sin_neg,
    output logic [FRAC_W-1:0]  cos_mag,
    output logic               cos_neg
);
    localparam int OW = PHASE_W - 3;

    // R9: the fold needs a period that is a multiple of four.
    if (PHASE_W < 4) begin : g_bad_width
        $error("octsc_unit: PHASE_W must be at least 4");
    end

    logic [OW-1:0]     addr;
    logic              diag;
    logic              swap;
    logic              sneg_c;
    logic              cneg_c;
    logic [FRAC_W-1:0] rd_sin;
    logic [FRAC_W-1:0] rd_cos;
    logic [FRAC_W-1:0] sin_c;
    logic [FRAC_W-1:0] cos_c;

    octsc_fold #(.PHASE_W(PHASE_W)) u_fold (
        .phase (in_phase),
        .addr  (addr),
        .diag  (diag),
        .swap  (swap),
        .sneg  (sneg_c),
        .cneg  (cneg_c)
    );

    octsc_rom #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W)) u_rom (
        .addr   (addr),
        .diag   (diag),
        .rd_sin (rd_sin),
        .rd_cos (rd_cos)
    );

    // Exchange the magnitudes in the octants that mirror across pi/4.
    always_comb begin
        sin_c = swap ? rd_cos : rd_sin;
        cos_c = swap ? rd_sin : rd_cos;
    end

    // Output register: cleared on reset, loaded only when in_valid is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sin_mag   <= '0;
            cos_mag   <= '0;
            sin_neg   <= 1'b0;
            cos_neg   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sin_mag <= sin_c;
                cos_mag <= cos_c;
                sin_neg <= sneg_c;
                cos_neg <= cneg_c;
            end
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sin_mag) && $stable(cos_mag)
                       && $stable(sin_neg) && $stable(cos_neg)));

    // R4
    sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sin_neg == $past(in_phase[PHASE_W-1])));

    // R5
    cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cos_neg == ($past(in_phase[PHASE_W-1]) ^ $past(in_phase[PHASE_W-2]))));

    // R6
    diag_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_phase[OW] && (in_phase[OW-1:0] == '0)) |=> (sin_mag == cos_mag));

    // R8
    quad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_phase[OW:0] == '0)) |=> ((sin_mag == '0) != (cos_mag == '0)));

endmodule

// File: tb/octsc_unit_tb.sv
module octsc_unit_tb;
    localparam int W    = 8;
    localparam int F    = 12;
    localparam int N    = 1 << W;
    localparam int FULL = (1 << F) - 1;
    localparam int DG   = 2896;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_phase = '0;
    logic         out_valid;
    logic [F-1:0] sin_mag;
    logic         sin_neg;
    logic [F-1:0] cos_mag;
    logic         cos_neg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    octsc_unit #(.PHASE_W(W), .FRAC_W(F)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
        .out_valid(out_valid), .sin_mag(sin_mag), .sin_neg(sin_neg),
        .cos_mag(cos_mag), .cos_neg(cos_neg)
    );

    // Vectors: {phase, sin_mag, cos_mag, sin_neg, cos_neg}
    localparam logic [33:0] VEC [8] = '{
        {8'd0,   12'd0,    12'd4095, 1'b0, 1'b0},  // R7 R8
        {8'd64,  12'd4095, 12'd0,    1'b0, 1'b1},  // R8
        {8'd128, 12'd0,    12'd4095, 1'b1, 1'b1},  // R8
        {8'd192, 12'd4095, 12'd0,    1'b1, 1'b0},  // R8
        {8'd32,  12'd2896, 12'd2896, 1'b0, 1'b0},  // R6
        {8'd96,  12'd2896, 12'd2896, 1'b0, 1'b1},  // R6
        {8'd160, 12'd2896, 12'd2896, 1'b1, 1'b1},  // R6
        {8'd224, 12'd2896, 12'd2896, 1'b1, 1'b0}   // R6
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input int act, input int exp);
        int d;
        d = act - exp;
        n_checks++;
        if (d > 1 || d < -1) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (+-1)", req, act, exp);
        end
    endtask

    // Drive one strobed index, then sample at the negedge after capture.
    task automatic apply(input int ph);
        @(negedge clk);
        in_valid = 1'b1;
        in_phase = W'(ph);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // R1: reset with the strobe high still clears everything.
        in_valid = 1'b1;
        in_phase = 8'd32;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 sin_mag", int'(sin_mag), 0);
        chk("R1 cos_mag", int'(cos_mag), 0);
        chk("R1 signs", int'({sin_neg, cos_neg}), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed vector table.
        for (int i = 0; i < 8; i++) begin
            apply(int'(VEC[i][33:26]));
            chk("R2 out_valid", int'(out_valid), 1);
            chk("R6/R7/R8 sin_mag", int'(sin_mag), int'(VEC[i][25:14]));
            chk("R6/R7/R8 cos_mag", int'(cos_mag), int'(VEC[i][13:2]));
            chk("R4 sin_neg", int'(sin_neg), int'(VEC[i][1]));
            chk("R5 cos_neg", int'(cos_neg), int'(VEC[i][0]));
        end

        // R3: exhaustive sweep against a real-valued model.
        for (int n = 0; n < N; n++) begin
            real ang;
            real es;
            real ec;
            int  e_s;
            int  e_c;
            ang = 2.0 * 3.14159265358979323846 * real'(n) / real'(N);
            es = $sin(ang);
            ec = $cos(ang);
            if (es < 0.0) es = -es;
            if (ec < 0.0) ec = -ec;
            e_s = $rtoi(es * real'(1 << F) + 0.5);
            e_c = $rtoi(ec * real'(1 << F) + 0.5);
            if (e_s > FULL) e_s = FULL;
            if (e_c > FULL) e_c = FULL;
            apply(n);
            chk_near("R3 sin_mag", int'(sin_mag), e_s);
            chk_near("R3 cos_mag", int'(cos_mag), e_c);
            chk("R4 sin_neg", int'(sin_neg), (n >> (W-1)) & 1);
            chk("R5 cos_neg", int'(cos_neg), ((n >> (W-1)) ^ (n >> (W-2))) & 1);
        end

        // R2: strobe low, phase changes, outputs hold.
        apply(32);
        in_phase = 8'd200;
        @(negedge clk);
        in_phase = 8'd0;
        @(negedge clk);
        chk("R2 out_valid low", int'(out_valid), 0);
        chk("R2 hold sin_mag", int'(sin_mag), DG);
        chk("R2 hold cos_mag", int'(cos_mag), DG);
        chk("R2 hold signs", int'({sin_neg, cos_neg}), 0);

        // R7 then R1: zero angle, then a reset clears it.
        apply(0);
        chk("R7 sin_mag", int'(sin_mag), 0);
        chk("R7 cos_mag", int'(cos_mag), FULL);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 cos_mag after reset", int'(cos_mag), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule